// File: doc/BRIEF.md
# NRZI Line Decoder with Stuffed-Bit Removal

This block sits behind a full-speed serial receiver that has already recovered the bit clock and resolved each line sample to J or K. On every cycle in which the sample enable is high it takes one line symbol. It turns the symbol into a data bit by comparing it with the symbol before. It tracks how many ones have arrived in a row, so that the zero a transmitter inserts after a long run of ones is dropped and a missing insertion is reported as an error. The next stage (byte assembly, packet decoding) gets one registered strobe per delivered data bit. It also gets a strobe for each dropped bit, which it can count, and a single-cycle error pulse.

A packet-active input frames the stream. While it is low, symbols are ignored and the decoder returns to its idle state. The reference line state goes back to J and the run of ones is cleared, so every packet starts clean. After a stuff error the block stays silent until packet-active falls.

Top module: `nrzi_unstuff_rx`

## Requirements
- R1: An accepted symbol (sym_en and pkt_active high) equal to the previous line state decodes as 1, and a change decodes as 0. In the cycle after acceptance, bit_vld is 1 and bit_data carries the decoded bit. sym_k encodes K as 1 and J as 0.
- R2: When the six decoded bits before an accepted symbol are all 1 and that symbol decodes as 0, the symbol is dropped. In the next cycle bit_vld stays 0 and unstuff_stb pulses for one cycle.
- R3: Only the stuffed bit is removed. The bits before and after it are delivered with bit_vld as usual.
- R4: When six decoded 1s are followed by another decoded 1, stuff_err pulses for one cycle in the cycle after that symbol, and bit_vld stays 0 for it.
- R5: Any decoded 0 clears the run of ones, including a dropped stuffed 0. Five 1s followed by a 0 deliver that 0 as data, and each run of six 1s is judged on its own.
- R6: After stuff_err, bit_vld, unstuff_stb and stuff_err stay 0 for every symbol until pkt_active has been low for at least one cycle.
- R7: While pkt_active is low, no output strobe is produced. The next packet's first symbol is compared against J, with the run of ones at zero.
- R8: A cycle with sym_en low produces no strobe and leaves the reference line state and the run count unchanged.
- R9: Synchronous reset clears all outputs and returns the state to that of R7.
- R10: At most one of bit_vld, unstuff_stb and stuff_err is high in any cycle, and each is high only in the cycle after an accepted symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_active | input | 1 | High while a packet is being received; low clears the decoder |
| sym_en | input | 1 | Sample enable: one line symbol is accepted per high cycle |
| sym_k | input | 1 | Line symbol, 1 = K, 0 = J |
| bit_vld | output | 1 | One-cycle strobe for a delivered data bit |
| bit_data | output | 1 | Decoded data bit, meaningful while bit_vld is high |
| unstuff_stb | output | 1 | One-cycle strobe for each dropped stuffed bit |
| stuff_err | output | 1 | One-cycle pulse when a run of seven 1s is seen |

## Verification
The assertions assume that sym_k, sym_en and pkt_active are synchronous to clk and settle well before each rising edge. They also assume that a packet can end (pkt_active low) at any cycle, so no property depends on a packet being complete. The stimulus changes every input only on the falling clock edge. It samples outputs on the falling edge that follows the accepting rising edge. It drives sym_en both back-to-back and with gaps, and it pulls pkt_active low mid-stream, including directly after an error, so the properties about clearing and silence are exercised within those assumptions.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;

    // Number of consecutive ones after which a zero must be inserted
    localparam int RUN_LIMIT_DEF = 6;

    typedef enum logic {
        LINE_J = 1'b0,
        LINE_K = 1'b1
    } line_t;

    // Decoded bit leaving the line decoder
    typedef struct packed {
        logic vld;
        logic val;
    } dec_bit_t;

    // Classification of one decoded bit by the run tracker
    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_DATA  = 2'd1,
        CLS_STUFF = 2'd2,
        CLS_ERR   = 2'd3
    } bit_cls_t;

    typedef struct packed {
        bit_cls_t cls;
        logic     val;
    } cls_bit_t;

    // NRZI: no transition means one, transition means zero
    function automatic logic nrzi_value(line_t prev, line_t cur);
        return (prev == cur);
    endfunction

endpackage

// File: rtl/nrzi_line_decode.sv
module nrzi_line_decode
    import nrzi_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pkt_active,
    input  logic     sym_en,
    input  logic     sym_k,
    output dec_bit_t dec
);

    line_t prev_line;
    line_t cur_line;

    assign cur_line = line_t'(sym_k);

    always_ff @(posedge clk) begin
        if (rst || !pkt_active) begin
            prev_line <= LINE_J;
        end else if (sym_en) begin
            prev_line <= cur_line;
        end
    end

    always_comb begin
        dec.vld = sym_en && pkt_active;
        dec.val = nrzi_value(prev_line, cur_line);
    end

    // Between packets the reference state returns to idle J
    assert_idle_line_is_j_R7: assert property (@(posedge clk) disable iff (rst)
        !pkt_active |=> (prev_line == LINE_J));

    // Without a sample enable the reference state holds
    assert_ref_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (pkt_active && !sym_en) |=> $stable(prev_line));

endmodule

// File: rtl/nrzi_run_tracker.sv
module nrzi_run_tracker
    import nrzi_rx_pkg::*;
#(
    parameter int RUN_LIMIT = RUN_LIMIT_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pkt_active,
    input  dec_bit_t dec,
    output cls_bit_t cls
);

    localparam int RUN_W = $clog2(RUN_LIMIT + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT);

    logic [RUN_W-1:0] run_cnt;
    logic             halted;

    always_comb begin
        cls.val = dec.val;
        if (!dec.vld || halted) begin
            cls.cls = CLS_NONE;
        end else if (run_cnt == RUN_MAX) begin
            cls.cls = dec.val ? CLS_ERR : CLS_STUFF;
        end else begin
            cls.cls = CLS_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pkt_active) begin
            run_cnt <= '0;
            halted  <= 1'b0;
        end else begin
            unique case (cls.cls)
                CLS_DATA:  run_cnt <= dec.val ? run_cnt + 1'b1 : '0;
                CLS_STUFF: run_cnt <= '0;
                CLS_ERR:   halted  <= 1'b1;
                default:   ;
            endcase
        end
    end

    assert_run_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= RUN_MAX);

    assert_zero_clears_run_R5: assert property (@(posedge clk) disable iff (rst)
        (pkt_active && dec.vld && !dec.val && !halted) |=> (run_cnt == '0));

    assert_halt_sticks_R6: assert property (@(posedge clk) disable iff (rst)
        (halted && pkt_active) |=> halted);

endmodule

// File: rtl/nrzi_out_stage.sv
module nrzi_out_stage
    import nrzi_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cls_bit_t cls,
    output logic     bit_vld,
    output logic     bit_data,
    output logic     unstuff_stb,
    output logic     stuff_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_vld     <= 1'b0;
            bit_data    <= 1'b0;
            unstuff_stb <= 1'b0;
            stuff_err   <= 1'b0;
        end else begin
            bit_vld     <= (cls.cls == CLS_DATA);
            bit_data    <= (cls.cls == CLS_DATA) && cls.val;
            unstuff_stb <= (cls.cls == CLS_STUFF);
            stuff_err   <= (cls.cls == CLS_ERR);
        end
    end

    assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bit_vld, unstuff_stb, stuff_err}));

    assert_quiet_after_error_R6: assert property (@(posedge clk) disable iff (rst)
        stuff_err |=> !(bit_vld || unstuff_stb || stuff_err));

endmodule

// File: rtl/nrzi_unstuff_rx.sv
module nrzi_unstuff_rx
    import nrzi_rx_pkg::*;
#(
    parameter int RUN_LIMIT = RUN_LIMIT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic pkt_active,
    input  logic sym_en,
    input  logic sym_k,
    output logic bit_vld,
    output logic bit_data,
    output logic unstuff_stb,
    output logic stuff_err
);

    dec_bit_t dec;
    cls_bit_t cls;

    nrzi_line_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .pkt_active (pkt_active),
        .sym_en     (sym_en),
        .sym_k      (sym_k),
        .dec        (dec)
    );

    nrzi_run_tracker #(.RUN_LIMIT(RUN_LIMIT)) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .pkt_active (pkt_active),
        .dec        (dec),
        .cls        (cls)
    );

    nrzi_out_stage u_out (
        .clk         (clk),
        .rst         (rst),
        .cls         (cls),
        .bit_vld     (bit_vld),
        .bit_data    (bit_data),
        .unstuff_stb (unstuff_stb),
        .stuff_err   (stuff_err)
    );

    // Every strobe traces back to a symbol accepted one cycle earlier
    assert_strobe_needs_symbol_R10: assert property (@(posedge clk) disable iff (rst)
        (bit_vld || unstuff_stb || stuff_err) |-> $past(sym_en && pkt_active && !rst));

endmodule

// File: tb/nrzi_unstuff_rx_test.sv
`timescale 1ns/1ps
module nrzi_unstuff_rx_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pkt_active = 1'b0;
    logic sym_en = 1'b0;
    logic sym_k = 1'b0;
    logic bit_vld, bit_data, unstuff_stb, stuff_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nrzi_unstuff_rx uut (
        .clk         (clk),
        .rst         (rst),
        .pkt_active  (pkt_active),
        .sym_en      (sym_en),
        .sym_k       (sym_k),
        .bit_vld     (bit_vld),
        .bit_data    (bit_data),
        .unstuff_stb (unstuff_stb),
        .stuff_err   (stuff_err)
    );

    // Row bits: {pkt, sym_k, exp_vld, exp_data, exp_unstuff, exp_err}
    localparam int NV = 38;
    localparam logic [5:0] VEC [0:NV-1] = '{
        6'b111000, 6'b111100, 6'b101000,                          // 0..2  R1
        6'b101100, 6'b101100, 6'b101100,
        6'b101100, 6'b101100, 6'b101100,                          // 3..8  six ones
        6'b110010,                                                // 9     R2 stuffed
        6'b111100, 6'b101000,                                     // 10,11 R3
        6'b101100, 6'b101100, 6'b101100,
        6'b101100, 6'b101100, 6'b101100,                          // 12..17
        6'b100001,                                                // 18    R4 error
        6'b110000, 6'b100000,                                     // 19,20 R6 silent
        6'b010000,                                                // 21    R7 pkt low
        6'b101100, 6'b111000,                                     // 22,23 R7 ref J
        6'b111100, 6'b111100, 6'b111100, 6'b111100, 6'b111100,    // 24..28 five ones
        6'b101000,                                                // 29    R5 zero is data
        6'b101100, 6'b101100, 6'b101100,
        6'b101100, 6'b101100, 6'b101100,                          // 30..35
        6'b110010,                                                // 36    R2
        6'b101000                                                 // 37    R5 run restarted
    };

    function automatic string req_of(int i);
        if (i == 9 || i == 36)      return "R2";
        if (i == 10)                return "R3";
        if (i == 18)                return "R4";
        if (i == 19 || i == 20)     return "R6";
        if (i >= 21 && i <= 23)     return "R7";
        if (i == 29 || i == 37)     return "R5";
        return "R1";
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: {vld,data,unstuff,err} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {bit_vld, bit_vld & bit_data, unstuff_stb, stuff_err};
    endfunction

    // Drive one symbol on the falling edge, sample after the next rising edge
    task automatic send(logic pkt, logic k);
        pkt_active = pkt;
        sym_k      = k;
        sym_en     = 1'b1;
        @(negedge clk);
        sym_en     = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pkt_active = 1'b1;
        sym_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", outs(), 4'b0000);          // reset holds outputs low
        rst = 1'b0;
        sym_en = 1'b0;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][5], VEC[i][4]);
            check(req_of(i), outs(), VEC[i][3:0]);
            n_checks++;
            if (!$onehot0({bit_vld, unstuff_stb, stuff_err})) begin
                n_fails++;
                $display("FAIL R10: strobes %b expected at most one set",
                         {bit_vld, unstuff_stb, stuff_err});
            end
        end

        // R8: no enable, no output, reference held at K
        pkt_active = 1'b0;
        @(negedge clk);
        send(1'b1, 1'b1);                      // J->K gives 0
        check("R8", outs(), 4'b1000);
        for (int j = 0; j < 4; j++) begin
            sym_k = j[0];
            @(negedge clk);
            check("R8", outs(), 4'b0000);
        end
        send(1'b1, 1'b1);                      // K again: unchanged -> 1
        check("R8", outs(), 4'b1100);

        // R9: mid-packet reset restores J reference
        send(1'b1, 1'b1);
        check("R1", outs(), 4'b1100);
        rst = 1'b1;
        @(negedge clk);
        check("R9", outs(), 4'b0000);
        rst = 1'b0;
        send(1'b1, 1'b1);                      // J->K after reset: 0
        check("R9", outs(), 4'b1000);

        // R9: reset clears run count; five ones then a sixth should be data
        for (int j = 0; j < 5; j++) begin
            send(1'b1, 1'b1);
            check("R1", outs(), 4'b1100);
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        send(1'b1, 1'b0);                      // J after reset: unchanged -> 1
        check("R9", outs(), 4'b1100);
        send(1'b1, 1'b1);                      // change -> 0, run short so data
        check("R9", outs(), 4'b1000);

        // R6: error then immediate packet end clears the halt
        for (int j = 0; j < 6; j++) send(1'b1, 1'b1);
        send(1'b1, 1'b1);
        check("R4", outs(), 4'b0001);
        send(1'b0, 1'b0);
        check("R7", outs(), 4'b0000);
        send(1'b1, 1'b0);
        check("R6", outs(), 4'b1100);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule